// File: doc/BRIEF.md
# Burst Data-Bus Target

This block answers transactions on a shared, synchronous bus that carries address and data on the same lines. An initiator opens a transaction by pulling the active-low `frame_n` low for one address cycle, in which the lines carry a word address and the `cmd` lines carry the command. If the address lies inside the target's window and the command is a read or a write, the target claims the transaction. It then moves one data word on every rising edge where its own ready output and the initiator's ready input are both low.

Bursts may be any length. The word address steps by one after each completed beat. The initiator marks its final beat by raising `frame_n` before that beat completes. Behind the bus sits a small word memory whose read latency is a parameter, so read bursts carry target wait states. On reads, the target leaves the data lines undriven for one turnaround cycle after the address phase. When a burst reaches the last word of the window, the target raises a stop request together with ready, and that beat ends the transaction.

The three-state data lines are modelled as separate `ad_in`, `ad_out` and `ad_oe` signals.

Top module: `burst_target`

## Requirements
- R1: While `rst_n` is low, `devsel_n`, `trdy_n` and `stop_n` are high and `ad_oe` is low.
- R2: A transaction starts on the first rising edge where `frame_n` is low after an edge where it was high. If `ad_in[AW-1:0]` lies in `[BASE, BASE+DEPTH)` and `cmd` is 4'b0110 (read) or 4'b0111 (write), `devsel_n` goes low in the next cycle and stays low until the transaction ends.
- R3: A start whose address lies outside the window, or whose command is any other code, is ignored. `devsel_n`, `trdy_n` and `stop_n` stay high, `ad_oe` stays low, and no memory word changes.
- R4: A beat happens only on an edge where `irdy_n` and `trdy_n` are both low. A write beat stores `ad_in` into the current word. During a read, `ad_out` shows the current word while `trdy_n` is low.
- R5: The word address rises by one after every beat.
- R6: A beat on an edge where `frame_n` is high is the last one. In the next cycle, `devsel_n` and `trdy_n` are high and `ad_oe` is low.
- R7: During a write, `trdy_n` is low in every data cycle.
- R8: In the cycle after a read's address phase, `ad_oe` is low and `trdy_n` is high. `ad_oe` is high for the rest of the read.
- R9: During a read, `trdy_n` goes low LAT+1 edges after the address-phase edge, or after the previous beat's edge, and stays low until the next beat.
- R10: `stop_n` is low exactly when `trdy_n` is low and the current word is offset DEPTH-1 of the window. A beat there ends the transaction whatever `frame_n` is.
- R11: While `trdy_n` is low and `irdy_n` is high, `trdy_n` and `ad_out` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every signal is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Transaction frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cmd | input | 4 | Command code, valid in the address cycle |
| ad_in | input | DW | Shared address/data lines as seen by the target |
| ad_out | output | DW | Read data driven toward the shared lines |
| ad_oe | output | 1 | High when the target drives the shared lines |
| devsel_n | output | 1 | Transaction claimed, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target requests the burst to end, active low |

## Verification
Every cycle, the bound checker confirms the following. Ready and stop only appear under a claim. A waiting initiator sees ready and read data held still. A final beat, or a stop beat, releases the bus in the next cycle. The data lines are never driven in the cycle the claim begins, and the word address steps by one per beat. Other behaviour only shows up across whole transactions, and the bench's scenarios cover it: exact wait-state counts for the configured latency, the data that round-trips through memory, transactions that must be ignored, and disconnects at the window end.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_WR,
      S_TURN,
      S_FETCH,
      S_WAIT,
      S_RDY
   } bt_state_t;

   localparam logic [3:0] CMD_RD = 4'b0110;
   localparam logic [3:0] CMD_WR = 4'b0111;
endpackage

// File: rtl/bt_claim.sv
module bt_claim
   import bt_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DEPTH = 16,
   parameter int BASE  = 64
) (
   input  logic [AW-1:0] addr,
   input  logic [3:0]    cmd,
   output logic          hit,
   output logic          is_rd
);
   localparam int IDX = $clog2(DEPTH);
   localparam logic [AW-1:0] BASE_V = AW'(BASE);

   logic in_win;

   generate
      if (IDX >= AW) begin : g_whole
         assign in_win = 1'b1;
      end else begin : g_slice
         assign in_win = (addr[AW-1:IDX] == BASE_V[AW-1:IDX]);
      end
   endgenerate

   assign is_rd = (cmd == CMD_RD);
   assign hit   = in_win && (is_rd || (cmd == CMD_WR));
endmodule

// File: rtl/bt_wordstore.sv
module bt_wordstore #(
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   parameter int LAT   = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DW-1:0]            wdata,
   input  logic                     re,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DW-1:0]            rdata,
   output logic                     rvalid
);
   logic [DW-1:0]  mem    [DEPTH];
   logic [DW-1:0]  pipe_d [LAT];
   logic [LAT-1:0] pipe_v;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      pipe_d[0] <= mem[raddr];
   end

   generate
      if (LAT == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_v <= '0;
            else        pipe_v <= re;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_v <= '0;
            else        pipe_v <= {pipe_v[LAT-2:0], re};
         end
         for (genvar s = 1; s < LAT; s++) begin : g_stage
            always_ff @(posedge clk) pipe_d[s] <= pipe_d[s-1];
         end
      end
   endgenerate

   assign rdata  = pipe_d[LAT-1];
   assign rvalid = pipe_v[LAT-1];
endmodule

// File: rtl/bt_seq.sv
module bt_seq
   import bt_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_n,
   input  logic          irdy_n,
   input  logic [AW-1:0] start_addr,
   input  logic          hit,
   input  logic          is_rd,
   input  logic          rvalid,
   input  logic [DW-1:0] rdata,
   output logic          we,
   output logic          re,
   output logic [AW-1:0] cur_addr,
   output logic [DW-1:0] ad_out,
   output logic          ad_oe,
   output logic          devsel_n,
   output logic          trdy_n,
   output logic          stop_n
);
   localparam int IDX = $clog2(DEPTH);
   localparam logic [IDX-1:0] LAST_IDX = IDX'(DEPTH - 1);

   bt_state_t     st;
   logic          frame_q;
   logic [AW-1:0] addr;
   logic [DW-1:0] hold_q;
   logic          start, data_st, at_end, beat, last;

   assign start   = (st == S_IDLE) && !frame_n && frame_q && hit;
   assign data_st = (st == S_WR) || (st == S_RDY);
   assign at_end  = (addr[IDX-1:0] == LAST_IDX);
   assign beat    = data_st && !irdy_n;
   assign last    = beat && (frame_n || at_end);

   assign trdy_n   = !data_st;
   assign stop_n   = !(data_st && at_end);
   assign devsel_n = (st == S_IDLE);
   assign ad_oe    = (st == S_FETCH) || (st == S_WAIT) || (st == S_RDY);
   assign ad_out   = hold_q;
   assign we       = beat && (st == S_WR);
   assign re       = (st == S_TURN) || (st == S_FETCH);
   assign cur_addr = addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         frame_q <= 1'b1;
         addr    <= '0;
         hold_q  <= '0;
      end else begin
         frame_q <= frame_n;
         unique case (st)
            S_IDLE: if (start) begin
               addr <= start_addr;
               st   <= is_rd ? S_TURN : S_WR;
            end
            S_WR: if (beat) begin
               addr <= addr + AW'(1);
               if (last) st <= S_IDLE;
            end
            S_TURN, S_FETCH: st <= S_WAIT;
            S_WAIT: if (rvalid) begin
               hold_q <= rdata;
               st     <= S_RDY;
            end
            S_RDY: if (beat) begin
               addr <= addr + AW'(1);
               st   <= last ? S_IDLE : S_FETCH;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/burst_target.sv
module burst_target
   import bt_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   parameter int BASE  = 64,
   parameter int LAT   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_n,
   input  logic          irdy_n,
   input  logic [3:0]    cmd,
   input  logic [DW-1:0] ad_in,
   output logic [DW-1:0] ad_out,
   output logic          ad_oe,
   output logic          devsel_n,
   output logic          trdy_n,
   output logic          stop_n
);
   localparam int IDX = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BASE % DEPTH != 0) begin : g_bad_base
      $error("BASE must be aligned to DEPTH");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least 1");
   end
   if (AW > DW || IDX > AW) begin : g_bad_width
      $error("AW must fit in DW and cover the window");
   end

   logic          hit, is_rd, we, re, rvalid;
   logic [AW-1:0] cur_addr;
   logic [DW-1:0] rdata;

   bt_claim #(.AW(AW), .DEPTH(DEPTH), .BASE(BASE)) u_claim (
      .addr  (ad_in[AW-1:0]),
      .cmd   (cmd),
      .hit   (hit),
      .is_rd (is_rd)
   );

   bt_seq #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (frame_n),
      .irdy_n     (irdy_n),
      .start_addr (ad_in[AW-1:0]),
      .hit        (hit),
      .is_rd      (is_rd),
      .rvalid     (rvalid),
      .rdata      (rdata),
      .we         (we),
      .re         (re),
      .cur_addr   (cur_addr),
      .ad_out     (ad_out),
      .ad_oe      (ad_oe),
      .devsel_n   (devsel_n),
      .trdy_n     (trdy_n),
      .stop_n     (stop_n)
   );

   bt_wordstore #(.DW(DW), .DEPTH(DEPTH), .LAT(LAT)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .waddr  (cur_addr[IDX-1:0]),
      .wdata  (ad_in),
      .re     (re),
      .raddr  (cur_addr[IDX-1:0]),
      .rdata  (rdata),
      .rvalid (rvalid)
   );
endmodule

// File: rtl/burst_target_chk.sv
module burst_target_chk #(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_n,
   input logic          irdy_n,
   input logic          trdy_n,
   input logic          stop_n,
   input logic          devsel_n,
   input logic          ad_oe,
   input logic [DW-1:0] ad_out,
   input logic [AW-1:0] cur_addr
);
   // R2: ready only under a claim
   p_trdy_claimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |-> !devsel_n);

   // R8: lines driven only under a claim, never in the claim's first cycle
   p_oe_claimed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> !devsel_n);
   p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |-> !ad_oe);

   // R10: stop always accompanies ready, and a stop beat ends the transaction
   p_stop_with_trdy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n |-> !trdy_n);
   p_stop_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_n && !irdy_n) |=> devsel_n);

   // R6: final beat releases the bus
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe));

   // R11: initiator wait holds ready and data
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out)));

   // R5: address steps by one per beat
   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && !irdy_n) |=> (cur_addr == $past(cur_addr) + AW'(1)));
endmodule

bind burst_target burst_target_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_n  (frame_n),
   .irdy_n   (irdy_n),
   .trdy_n   (trdy_n),
   .stop_n   (stop_n),
   .devsel_n (devsel_n),
   .ad_oe    (ad_oe),
   .ad_out   (ad_out),
   .cur_addr (cur_addr)
);

// File: tb/sim_burst_target.sv
module sim_burst_target;
   localparam int AW    = 16;
   localparam int DW    = 32;
   localparam int DEPTH = 16;
   localparam int BASE  = 64;
   localparam int LAT   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_n = 1'b1;
   logic          irdy_n = 1'b1;
   logic [3:0]    cmd = 4'h0;
   logic [DW-1:0] ad_in = '0;
   logic [DW-1:0] ad_out;
   logic          ad_oe, devsel_n, trdy_n, stop_n;

   int n_chk = 0;
   int n_err = 0;
   int cycles = 0;
   logic [31:0] wseed = 32'h1000_0000;

   always #2 clk = ~clk;

   burst_target #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BASE(BASE), .LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cmd(cmd),
      .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n),
      .trdy_n(trdy_n), .stop_n(stop_n)
   );

   task automatic check1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit            m_act = 0, m_rd = 0, m_turn = 0, m_pf = 1;
   int            m_addr = 0, m_cnt = 0;
   logic [DW-1:0] m_mem [DEPTH];

   function automatic bit e_trdy_n();
      return !(m_act && (!m_rd || m_cnt == 0));
   endfunction
   function automatic bit m_at_end();
      return (m_addr - BASE) == DEPTH - 1;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_act = 0; m_rd = 0; m_turn = 0; m_pf = 1; m_cnt = 0;
      end else begin
         if (m_act) begin
            bit tr;
            tr = e_trdy_n();
            m_turn = 0;
            if (!tr && !irdy_n) begin
               bit last;
               if (!m_rd) m_mem[m_addr - BASE] = ad_in;
               last = frame_n || m_at_end();
               m_addr++;
               if (last) m_act = 0;
               else if (m_rd) m_cnt = LAT + 1;
            end else if (m_rd && m_cnt > 0) begin
               m_cnt--;
            end
         end else if (!frame_n && m_pf) begin
            int a;
            a = int'(ad_in[AW-1:0]);
            if (a >= BASE && a < BASE + DEPTH && (cmd == 4'b0110 || cmd == 4'b0111)) begin
               m_act  = 1;
               m_rd   = (cmd == 4'b0110);
               m_addr = a;
               m_cnt  = m_rd ? LAT + 1 : 0;
               m_turn = m_rd;
            end
         end
         m_pf = frame_n;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         check1("R1 devsel_n in reset", {31'b0, devsel_n}, 32'd1);
         check1("R1 trdy_n in reset", {31'b0, trdy_n}, 32'd1);
         check1("R1 stop_n in reset", {31'b0, stop_n}, 32'd1);
         check1("R1 ad_oe in reset", {31'b0, ad_oe}, 32'd0);
      end else begin
         bit et, eo;
         et = e_trdy_n();
         eo = m_act && m_rd && !m_turn;
         check1("R2 R3 R6 devsel_n", {31'b0, devsel_n}, {31'b0, !m_act});
         check1(m_rd ? "R9 R11 read trdy_n" : "R7 R3 write trdy_n", {31'b0, trdy_n}, {31'b0, et});
         check1("R10 stop_n", {31'b0, stop_n}, {31'b0, !(m_act && !et && m_at_end())});
         check1("R8 ad_oe", {31'b0, ad_oe}, {31'b0, eo});
         if (eo && !et)
            check1("R4 R5 read data", ad_out, m_mem[m_addr - BASE]);
      end
   end

   always @(posedge clk) begin
      if (cycles > 100000) begin
         n_err++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   // ---------------- initiator ----------------
   task automatic burst(input logic [3:0] c, input int a, input int n, input int iwait);
      int  i = 0, w = 0, t = 0;
      bit  done = 0;
      @(negedge clk);
      frame_n = 1'b0; irdy_n = 1'b1; cmd = c; ad_in = DW'(a);
      while (!done) begin
         @(negedge clk);
         t++;
         cmd = 4'h0;
         ad_in = (c == 4'b0110) ? '0 : wseed + DW'(i);
         if (w < iwait) begin irdy_n = 1'b1; w++; end
         else irdy_n = 1'b0;
         frame_n = (i == n - 1 && !irdy_n) ? 1'b1 : 1'b0;
         if (!irdy_n && !trdy_n) begin
            if (!stop_n || i == n - 1) done = 1;
            i++; w = 0; t = 0;
         end
         if (devsel_n && t > LAT + 6) done = 1;   // no claim: give up
      end
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1; cmd = 4'h0;
      wseed = wseed + 32'h0101_0000;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: fill the whole window; target stops at the last word
      burst(4'b0111, BASE, DEPTH + 4, 0);
      // R4 R5 R9: plain read burst
      burst(4'b0110, BASE, 5, 0);
      // R11: read with initiator wait states
      burst(4'b0110, BASE + 3, 4, 2);
      // R7 R11: write with initiator wait states
      burst(4'b0111, BASE + 5, 3, 1);
      // R3: outside the window on both sides, then an unknown command
      burst(4'b0111, BASE + DEPTH, 2, 0);
      burst(4'b0111, BASE - 1, 2, 0);
      burst(4'b0011, BASE + 2, 2, 0);
      burst(4'b0110, BASE + DEPTH + 1, 1, 0);
      // R3 R10: full read shows word 2 untouched and stops at the end
      burst(4'b0110, BASE, DEPTH + 2, 0);
      // R6 R10: single beat on the last word
      burst(4'b0110, BASE + DEPTH - 1, 1, 0);
      // R6: single-beat write then read back
      burst(4'b0111, BASE + 7, 1, 0);
      burst(4'b0110, BASE + 6, 3, 1);
      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule